// File: doc/BRIEF.md
# Periodic Countdown Timer

A memory-mapped 32-bit down-counter with one interrupt line. Software loads a period, which is copied straight into the counter, and then starts or stops the count with strobe bits in the control word. While the timer runs, the counter drops by one on every clock cycle in which the external count-enable input is high. That input is the only way to slow the count down.

When the count runs out, a sticky timeout flag is set. In continuous mode the counter takes the period again and keeps running; in one-shot mode it parks at zero and halts. The interrupt output is the timeout flag gated by an enable bit. Software can read the live count at any time and clears the flag by writing anything to the status word.

The run state is a two-state machine. `ST_IDLE` moves to `ST_RUN` on a start strobe without a stop strobe ("arm"). `ST_RUN` moves back to `ST_IDLE` on a stop strobe ("halt"), or on an expiry in one-shot mode without a start strobe ("finish"). Every other combination holds the current state.

Top module: `cdtimer_top`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: An access is accepted only when `bus_be` is 4'hF and `bus_addr[1:0]` is 0. Other writes change nothing, and other reads return zero.
- R3: Status bit 0 is the timeout flag and bit 1 is the run state. `irq` equals the timeout flag AND control bit 0, and follows a register change from the next cycle.
- R4: A write to word 0 (status) clears the timeout flag, whatever the write data.
- R5: A write to word 2 (period) stores the value and loads the counter at the same edge. A snapshot read in the next cycle returns that value.
- R6: While the timer runs, the counter decrements by one in each cycle with `cnt_en` high, and holds its value when `cnt_en` is low.
- R7: A write to word 1 (control) stores all 32 bits. Bit 2 starts the count and bit 3 stops it, and stop wins when both are set.
- R8: Expiry happens on an enabled running cycle in which the count is 1 or 0, so a period P expires on its P-th enabled cycle. Expiry sets the timeout flag. With control bit 1 clear, the counter goes to 0 and halts.
- R9: With control bit 1 set, expiry reloads the period and the timer keeps running.
- R10: Writes to word 3 (snapshot) are ignored.
- R11: Word offsets 4 and above read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cnt_en | input | 1 | Count enable / prescaler tick |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is an expiry that lands exactly on the cycle chosen, because the bench must know the count at every step. The stimulus keeps `cnt_en` low during every bus access and raises it for a known number of cycles only. The live count is therefore predictable, and a one-shot expiry, a continuous reload and the following partial count can each be pinned to a known snapshot value. The flag, the run bit and `irq` are then read back before any clearing write.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // word indices (bus_addr[..:2])
    localparam int unsigned W_STATUS = 0;
    localparam int unsigned W_CTRL   = 1;
    localparam int unsigned W_PERIOD = 2;
    localparam int unsigned W_SNAP   = 3;

    // control bits
    localparam int unsigned C_IRQ_EN = 0;
    localparam int unsigned C_CONT   = 1;
    localparam int unsigned C_START  = 2;
    localparam int unsigned C_STOP   = 3;

    // status bits
    localparam int unsigned S_TIMEOUT = 0;
    localparam int unsigned S_RUNNING = 1;
endpackage

// File: rtl/cdtimer_decode.sv
module cdtimer_decode #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned BE_W   = 4,
    localparam int unsigned IDX_W = ADDR_W - 2
) (
    input  logic              sel,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_status,
    output logic              wr_ctrl,
    output logic              wr_period,
    output logic              rd_ok,
    output logic [IDX_W-1:0]  rd_idx
);
    import cdtimer_pkg::*;

    logic word_ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        word_ok   = (be == {BE_W{1'b1}}) && (addr[1:0] == 2'b00);
        idx       = addr[ADDR_W-1:2];
        wr_status = sel && we && word_ok && (idx == IDX_W'(W_STATUS));
        wr_ctrl   = sel && we && word_ok && (idx == IDX_W'(W_CTRL));
        wr_period = sel && we && word_ok && (idx == IDX_W'(W_PERIOD));
        rd_ok     = sel && !we && word_ok;
        rd_idx    = idx;
    end
endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status,
    input  logic              wr_ctrl,
    input  logic              wr_period,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] period,
    output logic              timeout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            period  <= '0;
            timeout <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl   <= wdata;
            if (wr_period) period <= wdata;
            if (expire)         timeout <= 1'b1;
            else if (wr_status) timeout <= 1'b0;
        end
    end

    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !expire) |=> !timeout); // R4
    AST_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> timeout); // R8
endmodule

// File: rtl/cdtimer_counter.sv
module cdtimer_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              cont,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expire
);
    import cdtimer_pkg::*;

    run_state_t state, state_nxt;

    // output process
    always_comb begin
        running = (state == ST_RUN);
        expire  = running && cnt_en && !load &&
                  ((count == '0) || (count == DATA_W'(1)));
    end

    // next-state process
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start_req && !stop_req) state_nxt = ST_RUN;      // arm
            ST_RUN: begin
                if (stop_req)                           state_nxt = ST_IDLE; // halt
                else if (expire && !cont && !start_req) state_nxt = ST_IDLE; // finish
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (load)               count <= load_val;
        else if (expire)             count <= cont ? period : '0;
        else if (running && cnt_en)  count <= count - DATA_W'(1);
    end

    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))); // R5
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_en && !load && count > DATA_W'(1))
        |=> (count == $past(count) - DATA_W'(1))); // R6
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !running); // R7
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont && !start_req) |=> (!running && count == '0)); // R8
    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cont && !stop_req) |=> (running && count == $past(period))); // R9
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8,
    localparam int unsigned IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_en,
    output logic              irq
);
    import cdtimer_pkg::*;

    logic wr_status, wr_ctrl, wr_period, rd_ok;
    logic [IDX_W-1:0] rd_idx;
    logic [DATA_W-1:0] ctrl, period, count;
    logic timeout, running, expire;

    cdtimer_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .sel(bus_sel), .we(bus_we), .be(bus_be), .addr(bus_addr),
        .wr_status(wr_status), .wr_ctrl(wr_ctrl), .wr_period(wr_period),
        .rd_ok(rd_ok), .rd_idx(rd_idx)
    );

    cdtimer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_status(wr_status), .wr_ctrl(wr_ctrl), .wr_period(wr_period),
        .wdata(bus_wdata), .expire(expire),
        .ctrl(ctrl), .period(period), .timeout(timeout)
    );

    cdtimer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .load(wr_period), .load_val(bus_wdata),
        .start_req(wr_ctrl && bus_wdata[C_START]),
        .stop_req(wr_ctrl && bus_wdata[C_STOP]),
        .cont(ctrl[C_CONT]), .period(period),
        .count(count), .running(running), .expire(expire)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (rd_idx)
                IDX_W'(W_STATUS): begin
                    bus_rdata[S_TIMEOUT] = timeout;
                    bus_rdata[S_RUNNING] = running;
                end
                IDX_W'(W_CTRL):   bus_rdata = ctrl;
                IDX_W'(W_PERIOD): bus_rdata = period;
                IDX_W'(W_SNAP):   bus_rdata = count;
                default:          bus_rdata = '0;
            endcase
        end
        irq = timeout && ctrl[C_IRQ_EN];
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !expire) |=> !irq); // R3
    AST_BAD_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_be != {BE_W{1'b1}}) |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/cdtimer_top_test.sv
module cdtimer_top_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, cnt_en = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    cdtimer_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_en(cnt_en), .irq(irq)
    );

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read cycle
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_we) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag, logic [3:0] be = 4'hF);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    task automatic run_en(int n);
        @(posedge clk); #2;
        cnt_en = 1'b1;
        repeat (n) @(posedge clk);
        #2;
        cnt_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 irq in reset", {31'b0, irq}, 32'd0);
        rst_n = 1'b1;
        rd(5'h00, 32'd0, "R1 status after reset");
        rd(5'h04, 32'd0, "R1 ctrl after reset");
        rd(5'h08, 32'd0, "R1 period after reset");
        rd(5'h0C, 32'd0, "R1 snapshot after reset");

        wr(5'h08, 32'd5);
        rd(5'h0C, 32'd5, "R5 snapshot loaded by period write");
        rd(5'h08, 32'd5, "R5 period stored");

        wr(5'h04, 32'h1);
        rd(5'h04, 32'h1, "R7 ctrl stored");
        rd(5'h00, 32'h0, "R7 no start, not running");

        wr(5'h04, 32'h5);
        rd(5'h00, 32'h2, "R3 running bit set after start");
        rd(5'h0C, 32'd5, "R6 holds with cnt_en low");

        run_en(2);
        rd(5'h0C, 32'd3, "R6 two enabled cycles decrement");

        run_en(3);
        check("R3 irq with flag and enable", {31'b0, irq}, 32'd1);
        rd(5'h00, 32'h1, "R8 one-shot expiry: flag set, halted");
        rd(5'h0C, 32'd0, "R8 one-shot parks at zero");

        wr(5'h00, 32'h0000_FFFE);
        check("R4 irq low after status write", {31'b0, irq}, 32'd0);
        rd(5'h00, 32'h0, "R4 flag cleared by any data");

        wr(5'h04, 32'hC);
        rd(5'h00, 32'h0, "R7 stop wins over start");

        wr(5'h08, 32'd3);
        wr(5'h04, 32'h6);
        run_en(3);
        check("R3 irq masked when enable clear", {31'b0, irq}, 32'd0);
        rd(5'h00, 32'h3, "R9 continuous expiry keeps running");
        rd(5'h0C, 32'd3, "R9 period reloaded");
        run_en(2);
        rd(5'h0C, 32'd1, "R9 counting resumes after reload");

        wr(5'h04, 32'h8);
        rd(5'h00, 32'h1, "R7 stop strobe halts");
        run_en(2);
        rd(5'h0C, 32'd1, "R6 stopped count holds");

        wr(5'h0C, 32'h77);
        rd(5'h0C, 32'd1, "R10 snapshot write ignored");
        rd(5'h08, 32'd3, "R10 period untouched");

        rd(5'h10, 32'd0, "R11 unmapped read zero");
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h04, 32'h8, "R11 unmapped write no effect on ctrl");
        rd(5'h08, 32'd3, "R11 unmapped write no effect on period");

        wr(5'h08, 32'd9, 4'h3);
        rd(5'h08, 32'd3, "R2 partial write ignored");
        wr(5'h09, 32'd9);
        rd(5'h0C, 32'd1, "R2 misaligned write ignored");
        rd(5'h08, 32'd0, "R2 partial read returns zero", 4'h1);

        @(posedge clk); #2;
        finish_run();
    end
endmodule